// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a 14-bit virtual address onto a physical address through four segment descriptors. The two top address bits pick a descriptor and the remaining twelve bits form the offset into that segment. Each descriptor holds a base, a bound, a valid flag and three permission flags (read, write, execute). A translation either returns base plus offset or one of three fault causes: the descriptor is invalid, the offset runs past the bound, or the access kind is not permitted.

Descriptors are loaded through a configuration port that only accepts writes marked as privileged. Requests enter on a single-cycle request port and are answered one clock later on a registered response port. A request always sees the descriptor contents as they stood before any configuration write made in the same cycle. Because each segment has its own permission flags, a segment that several address spaces share can be made read-only while the private segments stay writable.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_paddr and rsp_fault are all zero, and every descriptor is invalid, so any request faults as invalid until a descriptor is loaded.
- R2: The segment index is req_vaddr[13:12] and the offset is req_vaddr[11:0]; only the indexed descriptor affects the result.
- R3: When the offset is greater than or equal to the descriptor's bound, rsp_fault is 1 (bounds) and rsp_paddr is 0.
- R4: When the descriptor is valid, the offset is below the bound and the access is permitted, rsp_fault is 0 and rsp_paddr is base plus offset, modulo 2^16.
- R5: An invalid descriptor gives rsp_fault 2 (invalid) and rsp_paddr 0, whatever the bound and permissions hold.
- R6: req_kind 0 (read) needs perm bit 0, 1 (write) needs bit 1, 2 (execute) needs bit 2, and 3 is never permitted; a missing permission gives rsp_fault 3 (permission) with rsp_paddr 0, but only when the offset is within bound (bounds wins over permission).
- R7: rsp_valid is high in exactly the cycle after each cycle with req_valid high, including back-to-back requests; in a cycle with rsp_valid low, rsp_paddr and rsp_fault are 0.
- R8: A configuration write with cfg_priv low changes no descriptor.
- R9: A privileged configuration write made in the same cycle as a request does not change that request's result; the next request sees the new descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Write is privileged; unprivileged writes are dropped |
| cfg_seg | input | 2 | Descriptor index to write |
| cfg_base | input | 16 | Segment base address |
| cfg_bound | input | 13 | Segment size in bytes (0 to 4096) |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_valid | input | 1 | Descriptor valid flag |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 invalid, 3 permission |

## Verification
Each response is due one rising edge after its request, and a descriptor write becomes visible to requests presented from the cycle after the write edge. The bench drives every input on the falling edge, lets the rising edge capture it, and reads the response on the next falling edge, half a period after the register updated and before anything else can change it. Back-to-back and same-cycle-write cases sample each response on the falling edge that follows its own capturing edge, and the idle cycle after a request is read the same way to confirm that the response drops.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUNDS  = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PERM    = 2'd3
    } xl_fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } xl_access_e;

    localparam int PERM_W     = 3;
    localparam int PERM_READ  = 0;
    localparam int PERM_WRITE = 1;
    localparam int PERM_EXEC  = 2;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W   = 2,
    parameter int BASE_W  = 16,
    parameter int BOUND_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_priv,
    input  logic [SEG_W-1:0]   wr_idx,
    input  logic [BASE_W-1:0]  wr_base,
    input  logic [BOUND_W-1:0] wr_bound,
    input  logic [PERM_W-1:0]  wr_perm,
    input  logic               wr_valid,
    input  logic [SEG_W-1:0]   rd_idx,
    output logic [BASE_W-1:0]  rd_base,
    output logic [BOUND_W-1:0] rd_bound,
    output logic [PERM_W-1:0]  rd_perm,
    output logic               rd_valid
);

    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic [NSEG-1:0][BASE_W-1:0]  base;
        logic [NSEG-1:0][BOUND_W-1:0] bound;
        logic [NSEG-1:0][PERM_W-1:0]  perm;
        logic [NSEG-1:0]              vld;
    } tbl_t;

    tbl_t state_d, state_q;
    logic [NSEG-1:0] hit;

    // Per-descriptor write decode: a write lands only when privileged.
    for (genvar i = 0; i < NSEG; i++) begin : g_dec
        assign hit[i] = wr_en && wr_priv && (wr_idx == SEG_W'(i));
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NSEG; i++) begin
            if (hit[i]) begin
                state_d.base[i]  = wr_base;
                state_d.bound[i] = wr_bound;
                state_d.perm[i]  = wr_perm;
                state_d.vld[i]   = wr_valid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Read side sees the registered table only, so a write in the same
    // cycle cannot reach a request presented in that cycle.
    assign rd_base  = state_q.base[rd_idx];
    assign rd_bound = state_q.bound[rd_idx];
    assign rd_perm  = state_q.perm[rd_idx];
    assign rd_valid = state_q.vld[rd_idx];

    // R8: no table change without a privileged write
    assert_cfg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_priv) |=> $stable(state_q));

    // R9: a privileged write is visible from the following cycle
    assert_cfg_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_priv && (rd_idx == wr_idx)) |=> (rd_base == $past(wr_base)));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int BASE_W  = 16,
    parameter int BOUND_W = 13
) (
    input  logic [OFF_W-1:0]   offset,
    input  xl_access_e         kind,
    input  logic [BASE_W-1:0]  base,
    input  logic [BOUND_W-1:0] bound,
    input  logic [PERM_W-1:0]  perm,
    input  logic               entry_valid,
    output xl_fault_e          fault,
    output logic [BASE_W-1:0]  paddr
);

    logic              over_bound;
    logic              allowed;
    logic [BASE_W-1:0] sum;

    assign over_bound = (BOUND_W'(offset) >= bound);
    assign sum        = base + BASE_W'(offset);

    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = perm[PERM_READ];
            ACC_WRITE: allowed = perm[PERM_WRITE];
            ACC_EXEC:  allowed = perm[PERM_EXEC];
            default:   allowed = 1'b0;
        endcase
    end

    // Priority: invalid, then bounds, then permission.
    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        if (!entry_valid) begin
            fault = FLT_INVALID;
        end else if (over_bound) begin
            fault = FLT_BOUNDS;
        end else if (!allowed) begin
            fault = FLT_PERM;
        end else begin
            paddr = sum;
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int SEG_W = 2,
    parameter int PA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_priv,
    input  logic [SEG_W-1:0]           cfg_seg,
    input  logic [PA_W-1:0]            cfg_base,
    input  logic [VA_W-SEG_W:0]        cfg_bound,
    input  logic [2:0]                 cfg_perm,
    input  logic                       cfg_valid,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic [1:0]                 req_kind,
    output logic                       rsp_valid,
    output logic [PA_W-1:0]            rsp_paddr,
    output logic [1:0]                 rsp_fault
);

    localparam int OFF_W   = VA_W - SEG_W;
    localparam int BOUND_W = OFF_W + 1;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        xl_fault_e       fault;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [SEG_W-1:0]   seg_idx;
    logic [OFF_W-1:0]   offset;
    logic [PA_W-1:0]    sel_base;
    logic [BOUND_W-1:0] sel_bound;
    logic [PERM_W-1:0]  sel_perm;
    logic               sel_valid;
    xl_fault_e          chk_fault;
    logic [PA_W-1:0]    chk_paddr;

    assign seg_idx = req_vaddr[VA_W-1:OFF_W];
    assign offset  = req_vaddr[OFF_W-1:0];

    seg_regfile #(
        .SEG_W  (SEG_W),
        .BASE_W (PA_W),
        .BOUND_W(BOUND_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_priv (cfg_priv),
        .wr_idx  (cfg_seg),
        .wr_base (cfg_base),
        .wr_bound(cfg_bound),
        .wr_perm (cfg_perm),
        .wr_valid(cfg_valid),
        .rd_idx  (seg_idx),
        .rd_base (sel_base),
        .rd_bound(sel_bound),
        .rd_perm (sel_perm),
        .rd_valid(sel_valid)
    );

    seg_check #(
        .OFF_W  (OFF_W),
        .BASE_W (PA_W),
        .BOUND_W(BOUND_W)
    ) u_check (
        .offset     (offset),
        .kind       (xl_access_e'(req_kind)),
        .base       (sel_base),
        .bound      (sel_bound),
        .perm       (sel_perm),
        .entry_valid(sel_valid),
        .fault      (chk_fault),
        .paddr      (chk_paddr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.fault = FLT_NONE;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.paddr = chk_paddr;
            rsp_d.fault = chk_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;

    // R7: a response follows every request by exactly one cycle
    assert_resp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: no response without a request, and idle fields are zero
    assert_resp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_paddr == '0 && rsp_fault == 2'd0));

    // R3: a faulting response never carries an address
    assert_fault_no_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    // R5: an invalid descriptor always reports the invalid cause
    assert_invalid_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sel_valid) |=> (rsp_fault == 2'd2));

    // R3: an out-of-bound offset on a valid descriptor reports bounds
    assert_bound_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_valid && (BOUND_W'(offset) >= sel_bound)) |=> (rsp_fault == 2'd1));

endmodule

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [1:0]  cfg_seg = '0;
    logic [15:0] cfg_base = '0;
    logic [12:0] cfg_bound = '0;
    logic [2:0]  cfg_perm = '0;
    logic        cfg_valid = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    seg_xlate_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_priv (cfg_priv),
        .cfg_seg  (cfg_seg),
        .cfg_base (cfg_base),
        .cfg_bound(cfg_bound),
        .cfg_perm (cfg_perm),
        .cfg_valid(cfg_valid),
        .req_valid(req_valid),
        .req_vaddr(req_vaddr),
        .req_kind (req_kind),
        .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] seg, input logic [15:0] base,
                             input logic [12:0] bound, input logic [2:0] perm,
                             input logic vld, input logic priv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_seg = seg; cfg_base = base;
        cfg_bound = bound; cfg_perm = perm; cfg_valid = vld;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
    endtask

    // Present one request, read the response one edge later.
    task automatic xlate(input logic [13:0] va, input logic [1:0] kind,
                         input logic [1:0] exp_flt, input logic [15:0] exp_pa,
                         input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, {tag, " valid"}, int'(rsp_valid), 1);
        check(rsp_fault === exp_flt, {tag, " fault"}, int'(rsp_fault), int'(exp_flt));
        check(rsp_paddr === exp_pa, {tag, " paddr"}, int'(rsp_paddr), int'(exp_pa));
    endtask

    task automatic t_reset;
        check(rsp_valid === 1'b0, "R1 reset valid", int'(rsp_valid), 0);
        check(rsp_paddr === 16'h0, "R1 reset paddr", int'(rsp_paddr), 0);
        check(rsp_fault === 2'd0, "R1 reset fault", int'(rsp_fault), 0);
        for (int s = 0; s < 4; s++) begin
            xlate({2'(s), 12'h000}, 2'd0, 2'd2, 16'h0, "R1 unloaded descriptor");
        end
    endtask

    task automatic t_basic;
        cfg_write(2'd1, 16'h4000, 13'h800, 3'b111, 1'b1, 1'b1);
        xlate(14'h1010, 2'd0, 2'd0, 16'h4010, "R4 in-bound read");
        xlate(14'h17FF, 2'd1, 2'd0, 16'h47FF, "R4 last byte");
        xlate(14'h1800, 2'd0, 2'd1, 16'h0, "R3 offset equals bound");
        xlate(14'h1FFF, 2'd2, 2'd1, 16'h0, "R3 max offset");
        // R2: same offset, other segment (still invalid)
        xlate(14'h0010, 2'd0, 2'd2, 16'h0, "R2 segment select");
        // R7: idle cycle after a request
        @(negedge clk);
        check(rsp_valid === 1'b0, "R7 idle valid", int'(rsp_valid), 0);
        check(rsp_paddr === 16'h0, "R7 idle paddr", int'(rsp_paddr), 0);
    endtask

    task automatic t_wrap;
        cfg_write(2'd3, 16'hFF00, 13'h1000, 3'b011, 1'b1, 1'b1);
        xlate(14'h3FFF, 2'd1, 2'd0, 16'h0EFF, "R4 wrap at top");
        xlate(14'h3200, 2'd0, 2'd0, 16'h0100, "R4 wrap mid");
        xlate(14'h3000, 2'd0, 2'd0, 16'hFF00, "R4 zero offset");
    endtask

    task automatic t_perm;
        cfg_write(2'd2, 16'h2000, 13'h100, 3'b001, 1'b1, 1'b1);
        xlate(14'h2040, 2'd0, 2'd0, 16'h2040, "R6 read allowed");
        xlate(14'h2040, 2'd1, 2'd3, 16'h0, "R6 write denied");
        xlate(14'h2040, 2'd2, 2'd3, 16'h0, "R6 execute denied");
        xlate(14'h2040, 2'd3, 2'd3, 16'h0, "R6 reserved kind");
        xlate(14'h2100, 2'd1, 2'd1, 16'h0, "R6 bounds before permission");
        cfg_write(2'd2, 16'h2000, 13'h100, 3'b110, 1'b1, 1'b1);
        xlate(14'h2040, 2'd0, 2'd3, 16'h0, "R6 read denied");
        xlate(14'h2040, 2'd2, 2'd0, 16'h2040, "R6 execute allowed");
    endtask

    task automatic t_invalid;
        cfg_write(2'd0, 16'h1234, 13'h000, 3'b000, 1'b0, 1'b1);
        xlate(14'h0005, 2'd1, 2'd2, 16'h0, "R5 invalid over bound");
        cfg_write(2'd0, 16'h1234, 13'h1000, 3'b111, 1'b0, 1'b1);
        xlate(14'h0005, 2'd0, 2'd2, 16'h0, "R5 invalid in bound");
        cfg_write(2'd0, 16'h1234, 13'h000, 3'b111, 1'b1, 1'b1);
        xlate(14'h0000, 2'd0, 2'd1, 16'h0, "R3 zero bound");
    endtask

    task automatic t_priv;
        cfg_write(2'd1, 16'h9000, 13'h10, 3'b000, 1'b0, 1'b0);
        xlate(14'h1010, 2'd0, 2'd0, 16'h4010, "R8 unprivileged write dropped");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_seg = 2'd1; cfg_base = 16'h6000;
        cfg_bound = 13'h800; cfg_perm = 3'b111; cfg_valid = 1'b1;
        req_valid = 1'b1; req_vaddr = 14'h1010; req_kind = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
        check(rsp_paddr === 16'h4010, "R9 old descriptor used", int'(rsp_paddr), 16'h4010);
        // back-to-back second request, sees the new base
        req_vaddr = 14'h1020;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, "R7 back-to-back valid", int'(rsp_valid), 1);
        check(rsp_paddr === 16'h6020, "R9 new descriptor used", int'(rsp_paddr), 16'h6020);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R7 drop after burst", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wrap();
        t_perm();
        t_invalid();
        t_priv();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic t_reset_pre;
        check(rsp_valid === 1'b0, "R1 in reset valid", int'(rsp_valid), 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule